// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is a single logic cell of a small programmable array. A static configuration word selects, for each of five local AND terms, which signals enter the term in true form and which enter it inverted. The candidates are 36 lines of the routed signal bus and 16 lines of the shared-expander bus. The terms picked by an OR-enable mask are summed, and a polarity bit can invert the sum. The result is either registered or sent straight to the cell output.

The register can be clocked in three ways. The first uses a global clock, which is the true or inverted form of one of two clock pins. The second uses that same global clock, qualified by an enable that one product term computes. The third takes its clock directly from a product term. Two further terms can drive an asynchronous preset and an asynchronous clear, each under its own enable bit. An active-low global clear can also force the register low when its enable bit is set.

One term is offered to the rest of the group, inverted, as a shareable expander. Terms are fixed to roles: term 0 is the clock or enable term, term 1 the preset, term 2 the clear, and term 3 the expander. Any term can also feed the OR through the mask.

Top module: `mc_macrocell`

## Requirements
- R1: Literal index k (0 to 51) means routedIn[k] for k below 36 and expIn[k-36] otherwise. Term t owns cfgVec[t*104 +: 52] as true-select bits and cfgVec[t*104+52 +: 52] as invert-select bits. The term is the AND of every selected literal, and a term with no selected literal evaluates to 1.
- R2: The sum is the OR of the terms whose bit is set in cfgVec[524:520] (bit 520 is term 0). It is inverted when cfgVec[525] is 1. A term whose mask bit is clear has no effect on the sum.
- R3: When cfgVec[526] is 1, mcOut equals the sum in the same cycle, with no register in the path. When it is 0, mcOut shows the register.
- R4: expOut is always the complement of term 3.
- R5: The global clock is gclkPin[cfgVec[529]] XOR cfgVec[530]. With cfgVec[528:527] equal to 0, the register takes the sum on each rising edge of the global clock.
- R6: With cfgVec[528:527] equal to 1, a rising global-clock edge loads the register only while term 0 is 1, and the register otherwise holds. Mode value 3 behaves as mode 0.
- R7: With cfgVec[528:527] equal to 2, the register loads on each rising edge of term 0, and global-clock edges have no effect.
- R8: When cfgVec[531] is 1 and term 1 is 1, the register is set to 1 at once, without waiting for a clock.
- R9: When cfgVec[532] is 1 and term 2 is 1, the register is cleared to 0 at once.
- R10: When cfgVec[533] is 1 and gclrN is 0, the register is cleared at once. When cfgVec[533] is 0, gclrN has no effect.
- R11: When preset and clear are both active, the register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| routedIn | input | 36 | Routed signal bus, literals 0 to 35 |
| expIn | input | 16 | Shared-expander bus, literals 36 to 51 |
| gclkPin | input | 2 | The two global clock pins |
| gclrN | input | 1 | Active-low global clear |
| cfgVec | input | 534 | Static configuration word |
| mcOut | output | 1 | Registered or bypassed cell result |
| expOut | output | 1 | Inverted term 3, shared with the group |

## Verification
The assertions assume two things about the inputs. First, no data input changes in the same instant as a register clock edge. Second, preset and clear are never released one at a time while the other is still held. The bench keeps routed line 35 free for use as the array-clock literal, and it settles every input change before driving any clock pin. In the random phase, term-driven preset and clear stay disabled, so only clock edges move the register. Preset and clear are exercised in directed sequences that release both together.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    CLK_GLOBAL = 2'd0,
    CLK_GATED  = 2'd1,
    CLK_ARRAY  = 2'd2,
    CLK_SPARE  = 2'd3
  } clk_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic regClk;
    logic loadEn;
    logic asyncSet;
    logic asyncClr;
  } reg_strobe_t;

  // fixed roles of local terms
  localparam int TERM_CLK = 0;
  localparam int TERM_SET = 1;
  localparam int TERM_CLR = 2;
  localparam int TERM_EXP = 3;

endpackage

// File: rtl/mc_terms.sv
module mc_terms #(
  parameter int N_LIT   = 52,
  parameter int N_TERMS = 5
) (
  input  logic [N_LIT-1:0]           lits,
  input  logic [N_TERMS*2*N_LIT-1:0] selMask,
  output logic [N_TERMS-1:0]         termOut
);

  localparam int TERM_W = 2 * N_LIT;

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [N_LIT-1:0] trueSel;
    logic [N_LIT-1:0] invSel;
    assign trueSel = selMask[t*TERM_W +: N_LIT];
    assign invSel  = selMask[t*TERM_W + N_LIT +: N_LIT];
    // every selected literal must agree with its polarity
    assign termOut[t] = &((~trueSel | lits) & (~invSel | ~lits));
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  clk_mode_e   clkMode,
  input  logic [1:0]  gclkPin,
  input  logic        gclkSel,
  input  logic        gclkInv,
  input  logic        termClk,
  input  logic        termSet,
  input  logic        termClr,
  input  logic        presetEn,
  input  logic        clearEn,
  input  logic        gclrEn,
  input  logic        gclrN,
  output reg_strobe_t strobe
);

  logic globalClk;
  assign globalClk = gclkPin[gclkSel] ^ gclkInv;

  always_comb begin
    strobe.regClk   = (clkMode == CLK_ARRAY) ? termClk : globalClk;
    strobe.loadEn   = (clkMode == CLK_GATED) ? termClk : 1'b1;
    strobe.asyncSet = presetEn & termSet;
    strobe.asyncClr = (clearEn & termClr) | (gclrEn & ~gclrN);
  end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int N_TERMS = 5
) (
  input  reg_strobe_t        strobe,
  input  logic [N_TERMS-1:0] termIn,
  input  logic [N_TERMS-1:0] orMask,
  input  logic               xorInv,
  input  logic               bypass,
  input  logic               expTerm,
  output logic               dNext,
  output logic               regQ,
  output logic               mcOut,
  output logic               expOut
);

  logic rClk, aSet, aClr, loadEn;
  assign rClk   = strobe.regClk;
  assign aSet   = strobe.asyncSet;
  assign aClr   = strobe.asyncClr;
  assign loadEn = strobe.loadEn;

  assign dNext = (|(termIn & orMask)) ^ xorInv;

  // clear has priority over preset
  always_ff @(posedge rClk or posedge aClr or posedge aSet) begin
    if (aClr)        regQ <= 1'b0;
    else if (aSet)   regQ <= 1'b1;
    else if (loadEn) regQ <= dNext;
  end

  assign mcOut  = bypass ? dNext : regQ;
  assign expOut = ~expTerm;

endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int N_ROUTED = 36,
  parameter int N_EXP    = 16,
  parameter int N_TERMS  = 5
) (
  input  logic [N_ROUTED-1:0] routedIn,
  input  logic [N_EXP-1:0]    expIn,
  input  logic [1:0]          gclkPin,
  input  logic                gclrN,
  input  logic [N_TERMS*2*(N_ROUTED+N_EXP)+N_TERMS+9-1:0] cfgVec,
  output logic                mcOut,
  output logic                expOut
);

  localparam int N_LIT    = N_ROUTED + N_EXP;
  localparam int MASK_W   = N_TERMS * 2 * N_LIT;
  localparam int OR_LO    = MASK_W;
  localparam int XOR_BIT  = OR_LO + N_TERMS;
  localparam int BYP_BIT  = XOR_BIT + 1;
  localparam int MODE_LO  = BYP_BIT + 1;
  localparam int SEL_BIT  = MODE_LO + 2;
  localparam int INV_BIT  = SEL_BIT + 1;
  localparam int PEN_BIT  = INV_BIT + 1;
  localparam int CEN_BIT  = PEN_BIT + 1;
  localparam int GEN_BIT  = CEN_BIT + 1;

  logic [N_TERMS-1:0] terms;
  reg_strobe_t        strobe;
  clk_mode_e          clkMode;
  logic               dNext;
  logic               regQ;

  assign clkMode = clk_mode_e'(cfgVec[MODE_LO +: 2]);

  mc_terms #(.N_LIT(N_LIT), .N_TERMS(N_TERMS)) u_terms (
    .lits    ({expIn, routedIn}),
    .selMask (cfgVec[MASK_W-1:0]),
    .termOut (terms)
  );

  mc_ctrl u_ctrl (
    .clkMode  (clkMode),
    .gclkPin  (gclkPin),
    .gclkSel  (cfgVec[SEL_BIT]),
    .gclkInv  (cfgVec[INV_BIT]),
    .termClk  (terms[TERM_CLK]),
    .termSet  (terms[TERM_SET]),
    .termClr  (terms[TERM_CLR]),
    .presetEn (cfgVec[PEN_BIT]),
    .clearEn  (cfgVec[CEN_BIT]),
    .gclrEn   (cfgVec[GEN_BIT]),
    .gclrN    (gclrN),
    .strobe   (strobe)
  );

  mc_datapath #(.N_TERMS(N_TERMS)) u_dp (
    .strobe  (strobe),
    .termIn  (terms),
    .orMask  (cfgVec[OR_LO +: N_TERMS]),
    .xorInv  (cfgVec[XOR_BIT]),
    .bypass  (cfgVec[BYP_BIT]),
    .expTerm (terms[TERM_EXP]),
    .dNext   (dNext),
    .regQ    (regQ),
    .mcOut   (mcOut),
    .expOut  (expOut)
  );

endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk
  import mc_pkg::*;
(
  input logic        gclrN,
  input reg_strobe_t strobe,
  input logic        regQ,
  input logic        dNext
);

  logic rClk, anyAsync, quiet, asyncSeen;
  assign rClk     = strobe.regClk;
  assign anyAsync = strobe.asyncSet | strobe.asyncClr;
  assign quiet    = ~anyAsync;

  // remembers any async activity since the last register clock edge
  always_ff @(posedge rClk or posedge anyAsync) begin
    if (anyAsync) asyncSeen <= 1'b1;
    else          asyncSeen <= 1'b0;
  end

  // R5 R6 R7: an enabled edge leaves the sum in the register
  assert_load_R5: assert property (@(posedge rClk) disable iff (!gclrN)
    (!asyncSeen && quiet && $past(strobe.loadEn)) |-> (regQ == $past(dNext)));

  // R6: a disabled edge keeps the register
  assert_hold_R6: assert property (@(posedge rClk) disable iff (!gclrN)
    (!asyncSeen && quiet && !$past(strobe.loadEn)) |-> (regQ == $past(regQ)));

  // R9 R11: clear forces zero even with preset active
  assert_clear_wins_R11: assert property (@(posedge rClk) disable iff (!gclrN)
    strobe.asyncClr |-> (regQ == 1'b0));

  // R8: preset alone forces one
  assert_preset_R8: assert property (@(posedge rClk) disable iff (!gclrN)
    (strobe.asyncSet && !strobe.asyncClr) |-> (regQ == 1'b1));

endmodule

bind mc_macrocell mc_macrocell_chk u_chk (
  .gclrN  (gclrN),
  .strobe (strobe),
  .regQ   (regQ),
  .dNext  (dNext)
);

// File: tb/sim_mc_macrocell.sv
module sim_mc_macrocell;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int N_LIT      = 52;
  localparam int TERM_W     = 104;
  localparam int OR_LO      = 520;
  localparam int XOR_B      = 525;
  localparam int BYP_B      = 526;
  localparam int MODE_LO    = 527;
  localparam int SEL_B      = 529;
  localparam int INV_B      = 530;
  localparam int PEN_B      = 531;
  localparam int CEN_B      = 532;
  localparam int GEN_B      = 533;
  localparam int CFG_W      = 534;

  logic [35:0]      routedIn;
  logic [15:0]      expIn;
  logic [1:0]       gclkPin;
  logic             gclrN;
  logic [CFG_W-1:0] cfgVec;
  logic             mcOut, expOut;

  int  nChecks = 0;
  int  nFails  = 0;
  logic expQ = 1'b0;

  mc_macrocell u0 (
    .routedIn (routedIn),
    .expIn    (expIn),
    .gclkPin  (gclkPin),
    .gclrN    (gclrN),
    .cfgVec   (cfgVec),
    .mcOut    (mcOut),
    .expOut   (expOut)
  );

  function automatic logic litVal(input int k);
    return (k < 36) ? routedIn[k] : expIn[k-36];
  endfunction

  function automatic logic termVal(input int t);
    logic v = 1'b1;
    for (int k = 0; k < N_LIT; k++) begin
      if (cfgVec[t*TERM_W + k] && !litVal(k)) v = 1'b0;
      if (cfgVec[t*TERM_W + N_LIT + k] && litVal(k)) v = 1'b0;
    end
    return v;
  endfunction

  function automatic logic sumVal();
    logic acc = 1'b0;
    for (int t = 0; t < 5; t++)
      if (cfgVec[OR_LO + t]) acc = acc | termVal(t);
    return acc ^ cfgVec[XOR_B];
  endfunction

  function automatic logic clrNow();
    return (cfgVec[CEN_B] & termVal(2)) | (cfgVec[GEN_B] & ~gclrN);
  endfunction

  function automatic logic setNow();
    return cfgVec[PEN_B] & termVal(1);
  endfunction

  function automatic logic outNow();
    return cfgVec[BYP_B] ? sumVal() : expQ;
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic settle();
    #1;
    if (clrNow()) expQ = 1'b0;
    else if (setNow()) expQ = 1'b1;
  endtask

  task automatic setCfg(input logic [CFG_W-1:0] c);
    cfgVec  = c;
    gclkPin = {2{c[INV_B]}};
    settle();
  endtask

  task automatic setIn(input logic [35:0] r, input logic [15:0] e);
    routedIn = r;
    expIn    = e;
    settle();
  endtask

  // one rising edge of the global clock
  task automatic tickG();
    logic idx;
    logic [1:0] mode;
    idx  = cfgVec[SEL_B];
    mode = cfgVec[MODE_LO +: 2];
    gclkPin[idx] = ~cfgVec[INV_B];
    #1;
    if (mode != 2'd2 && !clrNow() && !setNow())
      if (mode != 2'd1 || termVal(0)) expQ = sumVal();
    #(HALF-1);
    gclkPin[idx] = cfgVec[INV_B];
    #HALF;
  endtask

  // one rising edge of term 0 through routed line 35
  task automatic tickArray();
    routedIn[35] = 1'b1;
    #1;
    if (!clrNow() && !setNow()) expQ = sumVal();
    #(HALF-1);
    routedIn[35] = 1'b0;
    #HALF;
  endtask

  function automatic logic [CFG_W-1:0] baseCfg();
    logic [CFG_W-1:0] c = '0;
    c[GEN_B] = 1'b1;
    c[SEL_B] = 1'b1;
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD*100000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [CFG_W-1:0] c;
    void'($urandom(32'd2024));
    routedIn = '0; expIn = '0; gclrN = 1'b0;
    c = '0; c[GEN_B] = 1'b1;
    cfgVec = c; gclkPin = 2'b00;
    settle();
    for (int i = 0; i < 3; i++) tickG();
    check("R10 reset", mcOut, 1'b0);
    gclrN = 1'b1;
    settle();
    check("R10 after release", mcOut, 1'b0);

    // R1 R3: literal polarity, bypass
    c = baseCfg();
    c[BYP_B] = 1'b1; c[OR_LO] = 1'b1;
    c[3] = 1'b1; c[36+2] = 1'b1; c[N_LIT+7] = 1'b1;
    setCfg(c);
    setIn(36'h8, 16'h4);
    check("R1 all literals agree", mcOut, 1'b1);
    check("R3 bypass matches", mcOut, outNow());
    setIn(36'h88, 16'h4);
    check("R1 inverted literal high", mcOut, 1'b0);
    setIn(36'h8, 16'h0);
    check("R1 expander literal low", mcOut, 1'b0);

    // R1 empty term, R2 polarity and mask
    c = baseCfg(); c[BYP_B] = 1'b1; c[OR_LO+4] = 1'b1;
    setCfg(c);
    check("R1 empty term is one", mcOut, 1'b1);
    c[XOR_B] = 1'b1; setCfg(c);
    check("R2 inversion", mcOut, 1'b0);
    c = baseCfg(); c[BYP_B] = 1'b1; c[OR_LO] = 1'b1; c[N_LIT+0] = 1'b1;
    setCfg(c);
    setIn(36'h1, 16'h0);
    check("R2 masked-out empty term ignored", mcOut, 1'b0);

    // R4 expander
    c = baseCfg(); c[3*TERM_W+5] = 1'b1; setCfg(c);
    setIn(36'h20, 16'h0);
    check("R4 expander term true", expOut, 1'b0);
    setIn(36'h0, 16'h0);
    check("R4 expander term false", expOut, 1'b1);

    // R5 global clock on pin 1, inverted
    c = baseCfg(); c[INV_B] = 1'b1; c[OR_LO+4] = 1'b1; setCfg(c);
    tickG();
    check("R5 load one", mcOut, 1'b1);
    c[XOR_B] = 1'b1; setCfg(c);
    check("R5 no load without edge", mcOut, 1'b1);
    tickG();
    check("R5 load zero", mcOut, 1'b0);

    // R6 gated by term 0 on routed line 10
    c = baseCfg(); c[MODE_LO] = 1'b1; c[OR_LO+4] = 1'b1; c[10] = 1'b1;
    setCfg(c);
    setIn(36'h0, 16'h0);
    tickG();
    check("R6 enable low holds", mcOut, 1'b0);
    setIn(36'h400, 16'h0);
    tickG();
    check("R6 enable high loads", mcOut, 1'b1);
    c[MODE_LO +: 2] = 2'd3; c[XOR_B] = 1'b1; setCfg(c);
    setIn(36'h0, 16'h0);
    tickG();
    check("R6 mode 3 acts as mode 0", mcOut, 1'b0);

    // R7 array clock on routed line 35
    c = baseCfg(); c[MODE_LO +: 2] = 2'd2; c[35] = 1'b1; c[OR_LO+4] = 1'b1;
    setCfg(c);
    tickG();
    check("R7 global edge ignored", mcOut, 1'b0);
    tickArray();
    check("R7 term edge loads", mcOut, 1'b1);

    // R8 R9 R11 async controls
    c = baseCfg(); c[PEN_B] = 1'b1; c[CEN_B] = 1'b1;
    c[1*TERM_W+20] = 1'b1; c[2*TERM_W+21] = 1'b1;
    setCfg(c);
    setIn(36'h0, 16'h0);
    tickG();
    check("R5 baseline zero", mcOut, 1'b0);
    setIn(36'h100000, 16'h0);
    check("R8 preset immediate", mcOut, 1'b1);
    setIn(36'h0, 16'h0);
    check("R8 preset held after release", mcOut, 1'b1);
    setIn(36'h200000, 16'h0);
    check("R9 clear immediate", mcOut, 1'b0);
    setIn(36'h0, 16'h0);
    setIn(36'h100000, 16'h0);
    setIn(36'h300000, 16'h0);
    check("R11 clear beats preset", mcOut, 1'b0);
    tickG();
    check("R11 clear beats preset over edge", mcOut, 1'b0);
    setIn(36'h0, 16'h0);

    // R10 global clear enable
    setIn(36'h100000, 16'h0);
    setIn(36'h0, 16'h0);
    c[GEN_B] = 1'b0; setCfg(c);
    gclrN = 1'b0; settle();
    check("R10 disabled global clear ignored", mcOut, 1'b1);
    c[GEN_B] = 1'b1; setCfg(c);
    check("R10 enabled global clear", mcOut, 1'b0);
    gclrN = 1'b1; settle();

    // random phase: clocked modes 0, 1, 3 with no term-driven async
    for (int it = 0; it < 400; it++) begin
      logic [1:0] m;
      c = '0;
      for (int t = 0; t < 5; t++)
        for (int k = 0; k < N_LIT; k++) begin
          if (k == 35) continue;
          if (($urandom & 15) == 0) c[t*TERM_W + k] = 1'b1;
          else if (($urandom & 15) == 0) c[t*TERM_W + N_LIT + k] = 1'b1;
        end
      c[OR_LO +: 5] = 5'($urandom);
      c[XOR_B] = 1'($urandom);
      c[BYP_B] = 1'($urandom);
      m = 2'($urandom);
      if (m == 2'd2) m = 2'd0;
      c[MODE_LO +: 2] = m;
      c[SEL_B] = 1'($urandom);
      c[INV_B] = 1'($urandom);
      c[GEN_B] = 1'b1;
      setCfg(c);
      setIn({1'b0, 35'($urandom) | (35'($urandom) << 32)}, 16'($urandom));
      check("R2 random sum", mcOut, outNow());
      check("R4 random expander", expOut, ~termVal(3));
      tickG();
      check(m == 2'd1 ? "R6 random gated edge" : "R5 random edge", mcOut, outNow());
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule